// File: doc/BRIEF.md
# Dual-Read General-Purpose Register File with Narrow Views

This block holds the integer working registers of a 64-bit processor model. It offers two combinational read ports and one clocked write port. Each access, read or write, picks either the full 64-bit register or a 32-bit view that covers only its low half.

Index 31 does not name a storage slot. It is a constant zero source: it reads as zero on either port and at either width, and a write aimed at it is dropped. A narrow write stores the low 32 bits of the write data and forces bits 63:32 of the target to zero. A narrow read returns the low half zero-extended to 64 bits and leaves the stored register untouched.

A write lands on the rising clock edge. There is no bypass, so a read of the register being written sees the old contents until that edge has passed. The pipeline that feeds the block resolves any forwarding it needs.

Top module: `gpr_file`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears every register, so all indices 0 to 30 then read as zero at both widths.
- R2: A full-width write (wr_narrow=0) with wr_en=1 to index 0..30 stores all 64 bits of wr_data, and a later full read returns them unchanged.
- R3: A narrow write (wr_narrow=1) stores wr_data[31:0] in bits 31:0 of the target and sets bits 63:32 to zero, whatever wr_data[63:32] holds.
- R4: A narrow read (rd_*_narrow=1) returns bits 31:0 of the selected register in bits 31:0 of the output and zero in bits 63:32. The stored upper half stays as it was and is visible on a later full read.
- R5: Read index 31 returns zero on either read port at either width, whatever was written.
- R6: A write to index 31 changes no register.
- R7: With wr_en=0 no register changes, whatever the other write inputs hold.
- R8: A read of the register under write in the same cycle returns its pre-write value. The new value appears only after the rising edge.
- R9: The two read ports are independent: each port returns the contents selected by its own index and width, whatever the other port selects.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 5 | Write register index (31 = zero register) |
| wr_narrow | input | 1 | 1 = 32-bit write, 0 = 64-bit write |
| wr_data | input | 64 | Write data |
| rd_a_idx | input | 5 | Port A read index |
| rd_a_narrow | input | 1 | Port A width select, 1 = 32-bit view |
| rd_a_data | output | 64 | Port A read data |
| rd_b_idx | input | 5 | Port B read index |
| rd_b_narrow | input | 1 | Port B width select, 1 = 32-bit view |
| rd_b_data | output | 64 | Port B read data |

## Verification
The assertions assume that every input is at a known 0/1 value whenever reset is low, and that reset is held high through the first clock edge so that the storage starts from a defined state. The bench drives every input at the falling edge, raises reset before the first rising edge, and never leaves an index, width select or data bus floating. The read-side properties can sample the combinational outputs at the clock because the indices are stable there.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  localparam int unsigned XLEN   = 64;
  localparam int unsigned HALF_W = XLEN / 2;
  localparam int unsigned IDX_W  = 5;
  localparam int unsigned SLOTS  = (1 << IDX_W) - 1;

  typedef logic [XLEN-1:0] word_t;

  // Shape data as it will be stored for a given write width.
  function automatic word_t write_shape(input word_t data, input logic narrow);
    word_t r;
    r = narrow ? {{HALF_W{1'b0}}, data[HALF_W-1:0]} : data;
    return r;
  endfunction

  // Shape a stored word for presentation on a read port.
  function automatic word_t read_shape(input word_t stored, input logic narrow);
    word_t r;
    r = narrow ? {{HALF_W{1'b0}}, stored[HALF_W-1:0]} : stored;
    return r;
  endfunction
endpackage

// File: rtl/gpr_store.sv
module gpr_store #(
  parameter int unsigned DATA_W = gpr_pkg::XLEN,
  parameter int unsigned IDX_W  = gpr_pkg::IDX_W,
  parameter int unsigned SLOTS  = gpr_pkg::SLOTS
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic                    wr_narrow,
  input  logic [DATA_W-1:0]       wr_data,
  output logic [SLOTS*DATA_W-1:0] store_flat
);
  localparam int unsigned FLAT_W = SLOTS * DATA_W;

  logic              commit_en;
  logic [DATA_W-1:0] commit_value;
  logic              zero_target;

  assign zero_target  = (32'(wr_idx) >= SLOTS);
  assign commit_en    = wr_en && !zero_target;
  assign commit_value = gpr_pkg::write_shape(wr_data, wr_narrow);

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        store_flat[g*DATA_W +: DATA_W] <= '0;
      else if (commit_en && (32'(wr_idx) == g))
        store_flat[g*DATA_W +: DATA_W] <= commit_value;
    end
  end

  function automatic logic [DATA_W-1:0] slot_of(input logic [FLAT_W-1:0] f,
                                                 input logic [IDX_W-1:0] i);
    return f[32'(i)*DATA_W +: DATA_W];
  endfunction

  // R2: a committed write shows in the selected slot after the edge
  a_r2_commit_lands: assert property (@(posedge clk) disable iff (rst)
    commit_en |=> slot_of(store_flat, $past(wr_idx)) == $past(commit_value));

  // R3: a narrow commit leaves the upper half at zero
  a_r3_narrow_upper_clear: assert property (@(posedge clk) disable iff (rst)
    (commit_en && wr_narrow) |=>
      slot_of(store_flat, $past(wr_idx))[DATA_W-1:DATA_W/2] == '0);

  // R6: writes to the zero index leave storage untouched
  a_r6_zero_discard: assert property (@(posedge clk) disable iff (rst)
    (wr_en && zero_target) |=> $stable(store_flat));

  // R7: no write strobe, no change
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(store_flat));
endmodule

// File: rtl/gpr_read_port.sv
module gpr_read_port #(
  parameter int unsigned DATA_W = gpr_pkg::XLEN,
  parameter int unsigned IDX_W  = gpr_pkg::IDX_W,
  parameter int unsigned SLOTS  = gpr_pkg::SLOTS
) (
  input  logic [SLOTS*DATA_W-1:0] store_flat,
  input  logic [IDX_W-1:0]        rd_idx,
  input  logic                    rd_narrow,
  output logic [DATA_W-1:0]       rd_data
);
  logic              hits_zero;
  logic [DATA_W-1:0] raw_word;

  assign hits_zero = (32'(rd_idx) >= SLOTS);

  always_comb begin
    raw_word = '0;
    if (!hits_zero)
      raw_word = store_flat[32'(rd_idx)*DATA_W +: DATA_W];
  end

  assign rd_data = gpr_pkg::read_shape(raw_word, rd_narrow);
endmodule

// File: rtl/gpr_file.sv
module gpr_file (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [4:0]  wr_idx,
  input  logic        wr_narrow,
  input  logic [63:0] wr_data,
  input  logic [4:0]  rd_a_idx,
  input  logic        rd_a_narrow,
  output logic [63:0] rd_a_data,
  input  logic [4:0]  rd_b_idx,
  input  logic        rd_b_narrow,
  output logic [63:0] rd_b_data
);
  localparam int unsigned DATA_W = gpr_pkg::XLEN;
  localparam int unsigned IDX_W  = gpr_pkg::IDX_W;
  localparam int unsigned SLOTS  = gpr_pkg::SLOTS;
  localparam int unsigned PORTS  = 2;

  logic [SLOTS*DATA_W-1:0] store_flat;
  logic [IDX_W-1:0]        port_idx    [PORTS];
  logic                    port_narrow [PORTS];
  logic [DATA_W-1:0]       port_data   [PORTS];

  assign port_idx[0]    = rd_a_idx;
  assign port_idx[1]    = rd_b_idx;
  assign port_narrow[0] = rd_a_narrow;
  assign port_narrow[1] = rd_b_narrow;
  assign rd_a_data      = port_data[0];
  assign rd_b_data      = port_data[1];

  gpr_store #(.DATA_W(DATA_W), .IDX_W(IDX_W), .SLOTS(SLOTS)) store_i (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_narrow  (wr_narrow),
    .wr_data    (wr_data),
    .store_flat (store_flat)
  );

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    gpr_read_port #(.DATA_W(DATA_W), .IDX_W(IDX_W), .SLOTS(SLOTS)) port_i (
      .store_flat (store_flat),
      .rd_idx     (port_idx[p]),
      .rd_narrow  (port_narrow[p]),
      .rd_data    (port_data[p])
    );

    // R5: the zero index always reads zero
    a_r5_zero_read: assert property (@(posedge clk) disable iff (rst)
      (port_idx[p] == 5'd31) |-> (port_data[p] == '0));

    // R4: narrow views are zero-extended
    a_r4_narrow_ext: assert property (@(posedge clk) disable iff (rst)
      port_narrow[p] |-> (port_data[p][DATA_W-1:DATA_W/2] == '0));
  end

  // R1: just after reset every port reads zero
  a_r1_reset_clear: assert property (@(posedge clk)
    $fell(rst) |-> (rd_a_data == '0 && rd_b_data == '0));
endmodule

// File: tb/gpr_file_tb.sv
module gpr_file_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_idx = '0;
  logic        wr_narrow = 1'b0;
  logic [63:0] wr_data = '0;
  logic [4:0]  rd_a_idx = '0;
  logic        rd_a_narrow = 1'b0;
  logic [63:0] rd_a_data;
  logic [4:0]  rd_b_idx = '0;
  logic        rd_b_narrow = 1'b0;
  logic [63:0] rd_b_data;

  int tests = 0;
  int fails = 0;
  logic [63:0] model [32];

  always #10 clk = ~clk;

  gpr_file dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_narrow(wr_narrow), .wr_data(wr_data),
    .rd_a_idx(rd_a_idx), .rd_a_narrow(rd_a_narrow), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_narrow(rd_b_narrow), .rd_b_data(rd_b_data)
  );

  function automatic logic [63:0] pattern(input int i, input int salt);
    logic [31:0] hi, lo;
    hi = 32'(i) * 32'h0101_0101 ^ 32'hF0F0_F0F0 ^ 32'(salt);
    lo = 32'(i) * 32'h1111_1111 + 32'h1234_5678 + 32'(salt * 7);
    return {hi, lo};
  endfunction

  function automatic logic [63:0] expect_read(input int i, input logic narrow);
    logic [63:0] v;
    v = (i == 31) ? 64'd0 : model[i];
    if (narrow) v = v & 64'h0000_0000_FFFF_FFFF;
    return v;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write(input int i, input logic [63:0] d, input logic narrow, input logic en);
    @(negedge clk);
    wr_en = en; wr_idx = 5'(i); wr_data = d; wr_narrow = narrow;
    @(negedge clk);
    wr_en = 1'b0;
    if (en && i != 31)
      model[i] = narrow ? {32'd0, d[31:0]} : d;
  endtask

  task automatic read_both(input string req, input int ia, input logic na,
                           input int ib, input logic nb);
    rd_a_idx = 5'(ia); rd_a_narrow = na;
    rd_b_idx = 5'(ib); rd_b_narrow = nb;
    #2;
    check(req, rd_a_data, expect_read(ia, na));
    check(req, rd_b_data, expect_read(ib, nb));
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < 32; i++) begin
      read_both(req, i, 1'b0, 31 - i, 1'b1);
      read_both(req, i, 1'b1, 31 - i, 1'b0);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 32; i++) model[i] = '0;
  endtask

  initial begin
    #4_000_000;
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;
    do_reset();
    sweep("R1");

    for (int i = 0; i < 31; i++) write(i, pattern(i, 0), 1'b0, 1'b1);
    sweep("R2 R4 R9");

    for (int i = 0; i < 31; i += 3) write(i, pattern(i, 5), 1'b1, 1'b1);
    sweep("R3");

    write(31, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b1);
    write(31, 64'h0123_4567_89AB_CDEF, 1'b1, 1'b1);
    sweep("R5 R6");

    for (int i = 0; i < 31; i += 4) write(i, ~pattern(i, 9), 1'b0, 1'b0);
    sweep("R7");

    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'd7; wr_narrow = 1'b0; wr_data = 64'hDEAD_BEEF_CAFE_F00D;
    read_both("R8", 7, 1'b0, 7, 1'b1);
    @(negedge clk);
    wr_en = 1'b0;
    model[7] = 64'hDEAD_BEEF_CAFE_F00D;
    read_both("R8", 7, 1'b0, 7, 1'b1);

    write(9, 64'hAAAA_BBBB_CCCC_DDDD, 1'b0, 1'b1);
    read_both("R4", 9, 1'b1, 9, 1'b1);
    read_both("R4", 9, 1'b0, 9, 1'b0);

    do_reset();
    sweep("R1");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule